// File: doc/BRIEF.md
# Nine-Level Stacked-Carrier Sine PWM Modulator

This block turns a signed sinusoidal reference sample into the switching state of one nine-level phase leg. A single up/down counter forms a triangle. From it the block derives eight triangular carriers, each occupying one unit-high band, with four bands above zero and four below. The reference is scaled by a modulation index and clamped to the carrier span. The output level, from -4 to +4 units, is the number of carriers the reference lies above minus four. The disposition of the carriers can be changed at run time. All carriers can run in the same phase. The upper half can run in antiphase to the lower half. Or neighbouring bands can alternate phase.

The same level also drives four series three-level cells. The cells are engaged in a fixed order, and each cell's two legs get their own gate pattern. The carrier period and the disposition mode are taken only when a carrier period begins. A control change therefore never leaves a partial carrier in the bank.

Top module: `mlvl_spwm`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `level_out` is 0, every cell code is 2'b00 and `gate_out` has 4'b0101 in every cell nibble. Reset leaves the counter at 0 counting up, with a terminal value of `TERM_DEF` and same-phase mode.
- R2: The counter steps by one every clock, rising from 0 to the terminal value T and falling back to 0. The period is 2T cycles. `term_in` is captured only on a cycle where the counter is 0, and a captured 0 is treated as 1.
- R3: The reference in carrier units is (ref_in * mi_in * 4 * T) arithmetically shifted right by (REF_W-1+MI_FRAC). Here ref_in is signed and mi_in is unsigned. The result is then clamped to the range [-4T, +4T].
- R4: For k = 0..7, carrier k is (k-4)*T + u, where u is the counter value or T minus the counter value. `level_out` equals the number of carriers strictly below the clamped reference, minus 4. That level is computed from the inputs and counter of one cycle and appears on `level_out` after the next clock edge.
- R5: With `mode_in` = 0, every carrier uses u = counter value. A mode value of 3 behaves the same.
- R6: With `mode_in` = 1, carriers 4..7 (the bands above zero) use u = T minus counter value, and carriers 0..3 use u = counter value.
- R7: With `mode_in` = 2, odd-numbered carriers use u = T minus counter value, and even-numbered carriers use u = counter value.
- R8: `mode_in` is captured only on a cycle where the counter is 0. The new disposition governs the comparisons from the following cycle on.
- R9: Cell i (i = 0..3, code in `cell_cmd[2i+1:2i]`) is 2'b01 (+1) when the level exceeds i, 2'b10 (-1) when the negated level exceeds i, and otherwise 2'b00. It is registered in the same cycle as `level_out`, so the cell codes always sum to `level_out`.
- R10: Nibble i of `gate_out` is {leg A high, leg A low, leg B high, leg B low}. The patterns are 4'b1001 for +1, 4'b0110 for -1 and 4'b0101 for 0, so a leg never has both of its switches on.
- R11: With same-phase mode, T = 8, unit modulation index and a reference of 1024 samples whose second half is the negation of its first half, the count of cycles at +k and at -k (k = 1..4) differs by at most 128 over that period.
- R12: With the reference at its most negative code and mi_in of at least 2^MI_FRAC, the next `level_out` is -4 in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the sample rate of the modulator |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | REF_W | Signed reference sample, full scale equals four units |
| mi_in | input | MI_W | Unsigned modulation index, 2^MI_FRAC is unity |
| term_in | input | CNT_W | Carrier terminal value T |
| mode_in | input | 2 | Disposition: 0 same phase, 1 upper/lower antiphase, 2 alternating bands, 3 same phase |
| level_out | output | LVL_W | Signed output level, -4 to +4 |
| cell_cmd | output | 2*NCELL | Per-cell code: 01 positive, 10 negative, 00 bypass |
| gate_out | output | 4*NCELL | Per-cell gate nibble {A high, A low, B high, B low} |

## Verification
The hardest cases to reach are changes of mode and terminal value that arrive partway through a carrier period. The old setting must keep governing until the counter next reaches zero, and after that the new one must take over. The stimulus flips the mode at arbitrary cycles, and sometimes changes T to values that include 0 and 1. A counter model in the bench captures settings only at the zero crossing, and every cycle's level is compared with it, so a capture made one cycle early or late shows up as a level mismatch. Separate odd-symmetric sine runs, and a clamped negative reference under overmodulation in every mode, cover level symmetry and saturation.

// File: rtl/mlvl_pkg.sv
package mlvl_pkg;

  typedef enum logic [1:0] {
    DISP_SAME  = 2'd0,
    DISP_HALF  = 2'd1,
    DISP_ALT   = 2'd2,
    DISP_SPARE = 2'd3
  } disp_e;

  // reference in carrier units: r * mi * ncell * t, arithmetic shift right
  function automatic longint scale_ref(longint r, longint mi, longint t,
                                       int ncell, int sh);
    return (r * mi * longint'(ncell) * t) >>> sh;
  endfunction

  function automatic longint clamp_ref(longint v, longint lim);
    if (v > lim)  return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

  // whether carrier k runs in antiphase for a given disposition
  function automatic bit carrier_flip(logic [1:0] m, int k, int ncell);
    case (m)
      DISP_HALF: return (k >= ncell);
      DISP_ALT:  return k[0];
      default:   return 1'b0;
    endcase
  endfunction

  function automatic longint carrier_value(int k, int ncell, longint cnt,
                                           longint t, bit flip);
    return longint'(k - ncell) * t + (flip ? (t - cnt) : cnt);
  endfunction

  // three-level code for cell idx given the leg level
  function automatic logic [1:0] cell_code(int lvl, int idx);
    if (lvl > idx)  return 2'b01;
    if (-lvl > idx) return 2'b10;
    return 2'b00;
  endfunction

  // {A high, A low, B high, B low}
  function automatic logic [3:0] cell_gates(logic [1:0] code);
    case (code)
      2'b01:   return 4'b1001;
      2'b10:   return 4'b0110;
      default: return 4'b0101;
    endcase
  endfunction

endpackage

// File: rtl/mlvl_carrier_gen.sv
module mlvl_carrier_gen #(
  parameter int CNT_W    = 10,
  parameter int TERM_DEF = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] term_in,
  input  logic [1:0]       mode_in,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] term_act,
  output logic [1:0]       mode_act,
  output logic             period_start
);

  logic             up;
  logic [CNT_W-1:0] term_nx;

  assign period_start = (cnt == '0);

  always_comb begin
    term_nx = term_act;
    if (period_start) term_nx = (term_in == '0) ? CNT_W'(1) : term_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      up       <= 1'b1;
      term_act <= CNT_W'(TERM_DEF);
      mode_act <= 2'd0;
    end else begin
      term_act <= term_nx;
      if (period_start) mode_act <= mode_in;
      if (up) begin
        cnt <= cnt + 1'b1;
        if (cnt + 1'b1 == term_nx) up <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) up <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/mlvl_carrier_bank.sv
module mlvl_carrier_bank #(
  parameter int NCELL   = 4,
  parameter int CNT_W   = 10,
  parameter int REF_W   = 16,
  parameter int MI_W    = 8,
  parameter int MI_FRAC = 7,
  parameter int LVL_W   = 4
) (
  input  logic [REF_W-1:0]        ref_in,
  input  logic [MI_W-1:0]         mi_in,
  input  logic [CNT_W-1:0]        cnt,
  input  logic [CNT_W-1:0]        term_act,
  input  logic [1:0]              mode_act,
  output logic signed [LVL_W-1:0] level
);

  localparam int NCAR = 2 * NCELL;
  localparam int SH   = REF_W - 1 + MI_FRAC;

  logic [NCAR-1:0]    above;
  logic signed [63:0] ref_sc;
  logic signed [63:0] ref_lim;
  logic signed [63:0] t_l;
  logic signed [63:0] c_l;

  assign t_l = longint'({1'b0, term_act});
  assign c_l = longint'({1'b0, cnt});

  always_comb begin
    ref_sc  = mlvl_pkg::scale_ref(longint'($signed(ref_in)),
                                  longint'({1'b0, mi_in}), t_l, NCELL, SH);
    ref_lim = mlvl_pkg::clamp_ref(ref_sc, longint'(NCELL) * t_l);
  end

  for (genvar k = 0; k < NCAR; k++) begin : g_car
    logic signed [63:0] cv;
    assign cv = mlvl_pkg::carrier_value(k, NCELL, c_l, t_l,
                  mlvl_pkg::carrier_flip(mode_act, k, NCELL));
    assign above[k] = (ref_lim > cv);
  end

  always_comb level = LVL_W'(int'($countones(above)) - NCELL);

endmodule

// File: rtl/mlvl_cell_map.sv
module mlvl_cell_map #(
  parameter int NCELL = 4,
  parameter int LVL_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [LVL_W-1:0] level,
  output logic [2*NCELL-1:0]      cell_cmd,
  output logic [4*NCELL-1:0]      gate_out
);

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    logic [1:0] code_q;
    logic [3:0] gate_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        code_q <= 2'b00;
        gate_q <= 4'b0101;
      end else begin
        code_q <= mlvl_pkg::cell_code(int'(level), i);
        gate_q <= mlvl_pkg::cell_gates(mlvl_pkg::cell_code(int'(level), i));
      end
    end
    assign cell_cmd[2*i +: 2] = code_q;
    assign gate_out[4*i +: 4] = gate_q;
  end

endmodule

// File: rtl/mlvl_spwm.sv
module mlvl_spwm #(
  parameter int NCELL    = 4,
  parameter int CNT_W    = 10,
  parameter int TERM_DEF = 8,
  parameter int REF_W    = 16,
  parameter int MI_W     = 8,
  parameter int MI_FRAC  = 7,
  parameter int LVL_W    = $clog2(NCELL + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [REF_W-1:0]        ref_in,
  input  logic [MI_W-1:0]         mi_in,
  input  logic [CNT_W-1:0]        term_in,
  input  logic [1:0]              mode_in,
  output logic signed [LVL_W-1:0] level_out,
  output logic [2*NCELL-1:0]      cell_cmd,
  output logic [4*NCELL-1:0]      gate_out
);

  logic [CNT_W-1:0]        cnt;
  logic [CNT_W-1:0]        term_act;
  logic [1:0]              mode_act;
  logic                    period_start;
  logic signed [LVL_W-1:0] level_now;

  mlvl_carrier_gen #(.CNT_W(CNT_W), .TERM_DEF(TERM_DEF)) u_gen (
    .clk(clk), .rst(rst), .term_in(term_in), .mode_in(mode_in),
    .cnt(cnt), .term_act(term_act), .mode_act(mode_act),
    .period_start(period_start)
  );

  mlvl_carrier_bank #(.NCELL(NCELL), .CNT_W(CNT_W), .REF_W(REF_W),
                      .MI_W(MI_W), .MI_FRAC(MI_FRAC), .LVL_W(LVL_W)) u_bank (
    .ref_in(ref_in), .mi_in(mi_in), .cnt(cnt), .term_act(term_act),
    .mode_act(mode_act), .level(level_now)
  );

  mlvl_cell_map #(.NCELL(NCELL), .LVL_W(LVL_W)) u_cells (
    .clk(clk), .rst(rst), .level(level_now),
    .cell_cmd(cell_cmd), .gate_out(gate_out)
  );

  always_ff @(posedge clk) begin
    if (rst) level_out <= '0;
    else     level_out <= level_now;
  end

endmodule

// File: rtl/mlvl_spwm_chk.sv
module mlvl_spwm_chk #(
  parameter int NCELL   = 4,
  parameter int CNT_W   = 10,
  parameter int REF_W   = 16,
  parameter int MI_W    = 8,
  parameter int MI_FRAC = 7,
  parameter int LVL_W   = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic [REF_W-1:0]        ref_in,
  input logic [MI_W-1:0]         mi_in,
  input logic [CNT_W-1:0]        cnt,
  input logic [CNT_W-1:0]        term_act,
  input logic [1:0]              mode_act,
  input logic                    period_start,
  input logic signed [LVL_W-1:0] level_out,
  input logic [2*NCELL-1:0]      cell_cmd,
  input logic [4*NCELL-1:0]      gate_out
);

  localparam logic [REF_W-1:0] MINREF = {1'b1, {(REF_W-1){1'b0}}};
  localparam logic [MI_W-1:0]  ONE_MI = MI_W'(1 << MI_FRAC);

  function automatic int cell_sum(logic [2*NCELL-1:0] c);
    int s = 0;
    for (int i = 0; i < NCELL; i++) begin
      if (c[2*i +: 2] == 2'b01) s++;
      else if (c[2*i +: 2] == 2'b10) s--;
    end
    return s;
  endfunction

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= term_act);  // R2
  AST_TERM_NONZERO: assert property (@(posedge clk) disable iff (rst)
    term_act != '0);  // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1));  // R2
  AST_MODE_AT_START: assert property (@(posedge clk) disable iff (rst)
    (mode_act != $past(mode_act)) |-> $past(period_start));  // R8
  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst)
    (int'(level_out) <= NCELL) && (int'(level_out) >= -NCELL));  // R4
  AST_CELL_SUM: assert property (@(posedge clk) disable iff (rst)
    cell_sum(cell_cmd) == int'(level_out));  // R9
  AST_NEG_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (ref_in == MINREF && mi_in >= ONE_MI) |=> (int'(level_out) == -NCELL));  // R12

  for (genvar i = 0; i < NCELL; i++) begin : g_leg
    AST_LEG_SAFE: assert property (@(posedge clk) disable iff (rst)
      !(gate_out[4*i+3] && gate_out[4*i+2]) &&
      !(gate_out[4*i+1] && gate_out[4*i]));  // R10
  end

  for (genvar i = 0; i + 1 < NCELL; i++) begin : g_ord
    AST_CELL_ORDER: assert property (@(posedge clk) disable iff (rst)
      (cell_cmd[2*(i+1) +: 2] != 2'b00) |->
      (cell_cmd[2*i +: 2] == cell_cmd[2*(i+1) +: 2]));  // R9
  end

endmodule

bind mlvl_spwm mlvl_spwm_chk #(
  .NCELL(NCELL), .CNT_W(CNT_W), .REF_W(REF_W),
  .MI_W(MI_W), .MI_FRAC(MI_FRAC), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst(rst), .ref_in(ref_in), .mi_in(mi_in), .cnt(cnt),
  .term_act(term_act), .mode_act(mode_act), .period_start(period_start),
  .level_out(level_out), .cell_cmd(cell_cmd), .gate_out(gate_out)
);

// File: tb/tb_mlvl_spwm.sv
`timescale 1ns/1ps
module tb_mlvl_spwm;

  localparam int NC  = 4;
  localparam int CW  = 10;
  localparam int TD  = 8;
  localparam int RW  = 16;
  localparam int MW  = 8;
  localparam int MF  = 7;
  localparam int LW  = 4;
  localparam int SHF = RW - 1 + MF;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [RW-1:0]        ref_in = '0;
  logic [MW-1:0]        mi_in = '0;
  logic [CW-1:0]        term_in = CW'(TD);
  logic [1:0]           mode_in = '0;
  logic signed [LW-1:0] level_out;
  logic [2*NC-1:0]      cell_cmd;
  logic [4*NC-1:0]      gate_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int m_cnt, m_up, m_term, m_mode;
  int hist[9];
  bit rec = 0;

  always #2.5 clk = ~clk;

  mlvl_spwm dut (
    .clk(clk), .rst(rst), .ref_in(ref_in), .mi_in(mi_in),
    .term_in(term_in), .mode_in(mode_in), .level_out(level_out),
    .cell_cmd(cell_cmd), .gate_out(gate_out)
  );

  function automatic int want_level(int r, int mi);
    longint t = longint'(m_term);
    longint rr = (longint'(r) * longint'(mi) * 4 * t) >>> SHF;
    int n = 0;
    if (rr > 4 * t) rr = 4 * t;
    if (rr < -4 * t) rr = -4 * t;
    for (int k = 0; k < 8; k++) begin
      bit fl;
      longint v;
      fl = (m_mode == 1) ? (k >= 4) : (m_mode == 2) ? (k % 2 == 1) : 1'b0;
      v = longint'(k - 4) * t + (fl ? t - longint'(m_cnt) : longint'(m_cnt));
      if (rr > v) n++;
    end
    return n - 4;
  endfunction

  function automatic logic [2*NC-1:0] want_cells(int lvl);
    logic [2*NC-1:0] c = '0;
    for (int i = 0; i < NC; i++)
      c[2*i +: 2] = (lvl > i) ? 2'b01 : (lvl < -i) ? 2'b10 : 2'b00;
    return c;
  endfunction

  function automatic logic [4*NC-1:0] want_gates(int lvl);
    logic [4*NC-1:0] g = '0;
    for (int i = 0; i < NC; i++)
      g[4*i +: 4] = (lvl > i) ? 4'b1001 : (lvl < -i) ? 4'b0110 : 4'b0101;
    return g;
  endfunction

  task automatic model_edge(input int t, input int md);
    if (m_cnt == 0) begin
      m_term = (t == 0) ? 1 : t;
      m_mode = md;
    end
    if (m_up == 1) begin
      m_cnt++;
      if (m_cnt == m_term) m_up = 0;
    end else begin
      m_cnt--;
      if (m_cnt == 0) m_up = 1;
    end
  endtask

  task automatic step(input int r, input int mi, input int t, input int md,
                      input string tag);
    int e;
    ref_in  = RW'(r);
    mi_in   = MW'(mi);
    term_in = CW'(t);
    mode_in = 2'(md);
    e = want_level(r, mi);
    model_edge(t, md);
    @(negedge clk);
    checks++;
    if (int'(level_out) != e) begin
      fails++;
      $display("FAIL %s level: actual %0d expected %0d", tag, level_out, e);
    end
    checks++;
    if (cell_cmd !== want_cells(e) || gate_out !== want_gates(e)) begin
      fails++;
      $display("FAIL R9/R10 %s cells: actual %h/%h expected %h/%h", tag,
               cell_cmd, gate_out, want_cells(e), want_gates(e));
    end
    if (rec) hist[int'(level_out) + 4]++;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int sine[1024];
    process::self().srandom(32'd1234);
    for (int n = 0; n < 512; n++) begin
      sine[n] = $rtoi(32700.0 * $sin(2.0 * 3.14159265358979 * n / 1024.0));
      sine[n + 512] = -sine[n];
    end

    repeat (4) @(negedge clk);
    // R1 reset state
    checks++;
    if (level_out !== '0 || cell_cmd !== '0 || gate_out !== 16'h5555) begin
      fails++;
      $display("FAIL R1 reset: actual %0d/%h/%h expected 0/0/5555",
               level_out, cell_cmd, gate_out);
    end
    rst = 1'b0;
    m_cnt = 0; m_up = 1; m_term = TD; m_mode = 0;
    // R1: first output after reset reflects the reset counter state
    step(0, 128, TD, 0, "R1");

    // R5 same phase, mid-band references of both signs
    for (int i = 0; i < 48; i++) step((i % 2) ? 12000 : -20000, 128, TD, 0, "R5");
    for (int i = 0; i < 32; i++) step(9000, 128, TD, 3, "R5");
    // R6 upper half antiphase
    for (int i = 0; i < 48; i++) step((i < 24) ? 13000 : -5000, 128, TD, 1, "R6");
    // R7 alternating bands
    for (int i = 0; i < 48; i++) step((i < 24) ? 21000 : -26000, 128, TD, 2, "R7");
    // R8 mode flipped at every cycle: capture only at counter zero
    for (int i = 0; i < 64; i++) step(17000, 128, TD, i % 3, "R8");
    // R2 terminal values 0, 1 and large, changed mid-period
    for (int i = 0; i < 40; i++) step(4000, 128, 0, 0, "R2");
    for (int i = 0; i < 40; i++) step(-7000, 128, 1, 2, "R2");
    for (int i = 0; i < 120; i++) step(30000, 100, (i < 60) ? 37 : 5, 1, "R2");
    // R3 / R12 overmodulation clamp in every mode
    for (int md = 0; md < 4; md++)
      for (int i = 0; i < 40; i++) step(-32768, 255, TD, md, "R12");
    for (int md = 0; md < 4; md++)
      for (int i = 0; i < 40; i++) step(32767, 255, TD, md, "R3");
    for (int i = 0; i < 40; i++) step(32767, 0, TD, 0, "R3");

    // R4 random references, indices, modes and terminal values
    begin
      int t = TD;
      int md = 0;
      for (int i = 0; i < 3000; i++) begin
        if ($urandom_range(0, 99) == 0) t = $urandom_range(0, 20);
        if ($urandom_range(0, 19) == 0) md = $urandom_range(0, 3);
        step($signed(16'($urandom)), $urandom_range(0, 255), t, md, "R4");
      end
    end

    // R11 symmetry over one fundamental, same phase, T = 8
    for (int i = 0; i < 32; i++) step(0, 128, 8, 0, "R11");
    foreach (hist[k]) hist[k] = 0;
    rec = 1;
    for (int n = 0; n < 1024; n++) step(sine[n], 128, 8, 0, "R11");
    rec = 0;
    for (int k = 1; k <= 4; k++) begin
      int d;
      d = hist[4 + k] - hist[4 - k];
      if (d < 0) d = -d;
      checks++;
      if (d > 128) begin
        fails++;
        $display("FAIL R11 level %0d: actual diff %0d expected <= 128", k, d);
      end
    end
    checks++;
    if (hist[8] == 0 || hist[0] == 0) begin
      fails++;
      $display("FAIL R11 extremes: actual %0d/%0d expected both nonzero",
               hist[8], hist[0]);
    end
    finish_run();
  end

endmodule